// File: doc/BRIEF.md
# I2C Target Address Front-End with High-Speed Entry

This block sits between the SCL/SDA pads and the rest of an I2C target. It samples both bus lines with a fast system clock and finds START, repeated START and STOP conditions. It shifts in the first byte after every START, compares it with its own 7-bit address, and drives the acknowledge bit through an open-drain enable. The address is a 6-bit base parameter with the low bit taken from a strap pin. The legal bases are 011010, 011011 and 011001, so six targets can share one bus. For an addressed write, each data byte that follows is handed to the core on a valid/ready stream.

The block also recognises the high-speed master code, which is any first byte of the form 00001xxx. It does not acknowledge that code. At the end of that acknowledge slot it raises a mode flag, which later bus-timing logic uses to switch to high-speed operation. The flag survives repeated STARTs and drops at STOP. A transaction strobe reports each address match together with its direction.

Back-pressure rule: the receive stream has a one-byte holding register. A byte is offered with `rx_valid` high and stays unchanged until the cycle in which `rx_ready` is high. A data byte that completes while the holding register is still full is not acknowledged and is discarded. The block then ignores the bus until the next START. Read transfers are recognised and acknowledged, but this front-end does not serve read data.

Top module: `i2c_hs_target`

## Requirements
- R1: During reset and right after it, `sda_oe`, `hs_mode`, `txn_start` and `rx_valid` are all 0.
- R2: A first byte after START whose upper seven bits, sent MSB first, equal {BASE_ADDR, a0_strap} is acknowledged. The block pulls SDA low (`sda_oe`=1) through the ninth clock. `txn_start` pulses for exactly one cycle, with `txn_rd` equal to bit 0 of the byte (1 = read).
- R3: `a0_strap` selects the address LSB. With the strap high, the address ending in 0 is refused and the address ending in 1 is accepted.
- R4: After a first byte that is neither the block's address nor the master code, SDA stays released in the ninth clock. Every later byte is then ignored (no acknowledge, no stream output) until the next START or repeated START.
- R5: A first byte matching 00001xxx is not acknowledged and produces no `txn_start`. `hs_mode` rises at the end of its ninth clock, while SDA is released.
- R6: `hs_mode` stays high across a repeated START and the high-speed transaction that follows it. A STOP (SDA rising while SCL is high) clears it.
- R7: After an acknowledged write address, each data byte is acknowledged and delivered on `rx_data`/`rx_valid` in bus order, MSB first.
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_data` is held. A data byte that completes during that time is not acknowledged and is lost.
- R9: After an acknowledged read address, the block releases SDA for the rest of the transfer and captures no data.
- R10: A repeated START restarts address recognition, even after an address mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| a0_strap | input | 1 | Strap giving the address LSB |
| sda_oe | output | 1 | 1 pulls SDA low; SDA is never driven high |
| hs_mode | output | 1 | High-speed mode flag |
| txn_start | output | 1 | One-cycle pulse on an address match |
| txn_rd | output | 1 | Direction of the last match, 1 = read |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Core takes the byte |
| rx_data | output | 8 | Received byte |

## Verification
The bench uses the default base 011010 and a two-stage synchronizer. This makes 0x34 and 0x35 the two strap-selected addresses. Both strap settings are run, so the refused-LSB case and the accepted case are both reached. Each SCL quarter period lasts ten system clocks, which is well above the synchronizer and edge-detect latency. As a result, every acknowledge decision lands inside SCL low, where the bench reads the resolved SDA level during the ninth clock. With this base the master code and the address never overlap, so the high-speed entry, its survival across a repeated START and its clearing at STOP can each be seen on their own.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_SLOT,
    ST_DATA,
    ST_DATA_SLOT,
    ST_HOLD
  } fe_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_evt_t;

  // 00001xxx: high-speed master code
  function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:BYTE_W-5] == 5'b00001;
  endfunction

endpackage

// File: rtl/i2c_fe_cond.sv
module i2c_fe_cond
  import i2c_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     sda_lvl,
  output bus_evt_t evt
);
  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] scl_sh, sda_sh;
  logic          scl_q, sda_q;
  logic          scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SW-2:0], scl_i};
      sda_sh <= {sda_sh[SW-2:0], sda_i};
      scl_q  <= scl_sh[SW-1];
      sda_q  <= sda_sh[SW-1];
    end
  end

  assign scl_s   = scl_sh[SW-1];
  assign sda_s   = sda_sh[SW-1];
  assign sda_lvl = sda_s;

  always_comb begin
    evt.scl_rise = scl_s & ~scl_q;
    evt.scl_fall = ~scl_s & scl_q;
    evt.start    = scl_s & scl_q & ~sda_s & sda_q;
    evt.stop     = scl_s & scl_q & sda_s & ~sda_q;
  end

endmodule

// File: rtl/i2c_fe_engine.sv
module i2c_fe_engine
  import i2c_fe_pkg::*;
#(
  parameter logic [5:0] BASE_ADDR = 6'b011010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_evt_t          evt,
  input  logic              sda_lvl,
  input  logic              a0_strap,
  input  logic              buf_full,
  output logic              sda_oe,
  output logic              hs_mode,
  output logic              txn_start,
  output logic              txn_rd,
  output logic              push,
  output logic [BYTE_W-1:0] push_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  fe_state_e         state;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              byte_done;
  logic              hs_pend;
  logic              rd_mode;
  logic              nacked;
  logic [6:0]        own_addr;

  assign own_addr  = {BASE_ADDR, a0_strap};
  assign push_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sh        <= '0;
      cnt       <= '0;
      byte_done <= 1'b0;
      hs_pend   <= 1'b0;
      rd_mode   <= 1'b0;
      nacked    <= 1'b0;
      sda_oe    <= 1'b0;
      hs_mode   <= 1'b0;
      txn_start <= 1'b0;
      txn_rd    <= 1'b0;
      push      <= 1'b0;
    end else begin
      txn_start <= 1'b0;
      push      <= 1'b0;
      if (evt.stop) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        hs_mode   <= 1'b0;
        hs_pend   <= 1'b0;
        byte_done <= 1'b0;
      end else if (evt.start) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        hs_pend   <= 1'b0;
        byte_done <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (evt.scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
              if (cnt == LAST_BIT) byte_done <= 1'b1;
            end else if (evt.scl_fall && byte_done) begin
              byte_done <= 1'b0;
              if (state == ST_ADDR) begin
                if (is_hs_code(sh)) begin
                  hs_pend <= 1'b1;
                  state   <= ST_ADDR_SLOT;
                end else if (sh[BYTE_W-1:1] == own_addr) begin
                  sda_oe    <= 1'b1;
                  txn_start <= 1'b1;
                  txn_rd    <= sh[0];
                  rd_mode   <= sh[0];
                  state     <= ST_ADDR_SLOT;
                end else begin
                  state <= ST_HOLD;
                end
              end else begin
                nacked <= buf_full;
                state  <= ST_DATA_SLOT;
                if (!buf_full) begin
                  push   <= 1'b1;
                  sda_oe <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_SLOT: begin
            if (evt.scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (hs_pend) begin
                hs_mode <= 1'b1;
                hs_pend <= 1'b0;
                state   <= ST_HOLD;
              end else if (rd_mode) begin
                state <= ST_HOLD;
              end else begin
                state <= ST_DATA;
              end
            end
          end
          ST_DATA_SLOT: begin
            if (evt.scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= nacked ? ST_HOLD : ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_fe_rxbuf.sv
module i2c_fe_rxbuf
  import i2c_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (push && !rx_valid) begin
      rx_valid <= 1'b1;
      rx_data  <= push_data;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_hs_target.sv
module i2c_hs_target
  import i2c_fe_pkg::*;
#(
  parameter logic [5:0] BASE_ADDR   = 6'b011010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       a0_strap,
  output logic       sda_oe,
  output logic       hs_mode,
  output logic       txn_start,
  output logic       txn_rd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data
);
  bus_evt_t          evt;
  logic              sda_lvl;
  logic              push;
  logic [BYTE_W-1:0] push_data;

  i2c_fe_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_lvl (sda_lvl),
    .evt     (evt)
  );

  i2c_fe_engine #(.BASE_ADDR(BASE_ADDR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .sda_lvl   (sda_lvl),
    .a0_strap  (a0_strap),
    .buf_full  (rx_valid),
    .sda_oe    (sda_oe),
    .hs_mode   (hs_mode),
    .txn_start (txn_start),
    .txn_rd    (txn_rd),
    .push      (push),
    .push_data (push_data)
  );

  i2c_fe_rxbuf u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .rx_ready  (rx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
  );

endmodule

// File: rtl/i2c_hs_target_chk.sv
module i2c_hs_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       hs_mode,
  input logic       txn_start,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!sda_oe && !hs_mode && !rx_valid && !txn_start));

  p_txn_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> !txn_start);

  p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i);

  p_hs_enter_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> (!sda_oe && !scl_i));

  p_hs_leave_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_mode) |-> scl_i);

  p_push_acked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> sda_oe);

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

endmodule

bind i2c_hs_target i2c_hs_target_chk u_chk (.*);

// File: tb/i2c_hs_target_test.sv
module i2c_hs_target_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       a0 = 1'b0;
  logic       rdy = 1'b1;
  logic       sda_oe, hs_mode, txn_start, txn_rd, rx_valid;
  logic [7:0] rx_data;
  logic       sda_bus;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [7:0] exp_rx[$];
  logic       exp_txn[$];

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_hs_target uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .a0_strap  (a0),
    .sda_oe    (sda_oe),
    .hs_mode   (hs_mode),
    .txn_start (txn_start),
    .txn_rd    (txn_rd),
    .rx_valid  (rx_valid),
    .rx_ready  (rdy),
    .rx_data   (rx_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    acked = ~sda_bus;
    wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid && rdy) begin
      if (exp_rx.size() == 0) check(1'b0, "R7 unexpected byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R7 rx byte", rx_data, e);
      end
    end
    if (rst_n && txn_start) begin
      if (exp_txn.size() == 0) check(1'b0, "R4 unexpected txn_start", 1, 0);
      else begin
        logic e;
        e = exp_txn.pop_front();
        check(txn_rd == e, "R2 txn_rd", txn_rd, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    repeat (3) @(negedge clk);
    check(!sda_oe && !hs_mode && !rx_valid && !txn_start, "R1 in reset",
          {sda_oe, hs_mode, rx_valid, txn_start}, 0);
    rst_n = 1'b1;
    wait_q();
    check(!sda_oe && !hs_mode && !rx_valid && !txn_start, "R1 after reset",
          {sda_oe, hs_mode, rx_valid, txn_start}, 0);

    // R2 / R7: write to 0110100 with strap low
    a0 = 1'b0;
    bus_start();
    exp_txn.push_back(1'b0);
    send_byte(8'h68, ak); check(ak, "R2 address ack", ak, 1);
    exp_rx.push_back(8'hA5);
    send_byte(8'hA5, ak); check(ak, "R7 data ack", ak, 1);
    exp_rx.push_back(8'h3C);
    send_byte(8'h3C, ak); check(ak, "R7 data ack", ak, 1);
    bus_stop();
    wait_q();

    // R3 / R4: strap high, LSB-0 address refused, later bytes ignored
    a0 = 1'b1;
    wait_q();
    bus_start();
    send_byte(8'h68, ak); check(!ak, "R3 address LSB 0 refused", ak, 0);
    send_byte(8'h11, ak); check(!ak, "R4 ignored after mismatch", ak, 0);
    check(!rx_valid, "R4 no stream output", rx_valid, 0);
    bus_stop();
    bus_start();
    exp_txn.push_back(1'b0);
    send_byte(8'h6A, ak); check(ak, "R3 address LSB 1 accepted", ak, 1);
    exp_rx.push_back(8'h5A);
    send_byte(8'h5A, ak); check(ak, "R7 data ack", ak, 1);
    bus_stop();
    wait_q();

    // R5 / R6: master code, then repeated START keeps high-speed mode
    check(!hs_mode, "R6 fast mode before code", hs_mode, 0);
    bus_start();
    send_byte(8'h0D, ak); check(!ak, "R5 master code NACK", ak, 0);
    check(hs_mode, "R5 hs_mode after code", hs_mode, 1);
    bus_rstart();
    check(hs_mode, "R6 hs_mode across Sr", hs_mode, 1);
    exp_txn.push_back(1'b0);
    send_byte(8'h6A, ak); check(ak, "R6 hs address ack", ak, 1);
    exp_rx.push_back(8'h77);
    send_byte(8'h77, ak); check(ak, "R6 hs data ack", ak, 1);
    check(hs_mode, "R6 hs_mode during transfer", hs_mode, 1);
    bus_stop();
    wait_q();
    check(!hs_mode, "R6 hs_mode cleared by STOP", hs_mode, 0);

    // R9: read address acked, then released
    bus_start();
    exp_txn.push_back(1'b1);
    send_byte(8'h6B, ak); check(ak, "R9 read address ack", ak, 1);
    send_byte(8'hFF, ak); check(!ak, "R9 SDA released after read ack", ak, 0);
    check(!rx_valid, "R9 no capture on read", rx_valid, 0);
    bus_stop();
    wait_q();

    // R8: back-pressure
    rdy = 1'b0;
    bus_start();
    exp_txn.push_back(1'b0);
    send_byte(8'h6A, ak); check(ak, "R8 address ack", ak, 1);
    send_byte(8'h21, ak); check(ak, "R8 first byte ack", ak, 1);
    send_byte(8'h42, ak); check(!ak, "R8 second byte NACK", ak, 0);
    check(rx_valid && rx_data == 8'h21, "R8 held byte", rx_data, 8'h21);
    bus_stop();
    exp_rx.push_back(8'h21);
    rdy = 1'b1;
    wait_q();
    check(!rx_valid, "R8 byte taken", rx_valid, 0);

    // R10: mismatch, then repeated START with own address
    bus_start();
    send_byte(8'h44, ak); check(!ak, "R10 mismatch NACK", ak, 0);
    bus_rstart();
    exp_txn.push_back(1'b0);
    send_byte(8'h6A, ak); check(ak, "R10 address after Sr ack", ak, 1);
    exp_rx.push_back(8'h99);
    send_byte(8'h99, ak); check(ak, "R10 data ack", ak, 1);
    bus_stop();
    wait_q(); wait_q();

    check(exp_rx.size() == 0, "R7 all bytes delivered", exp_rx.size(), 0);
    check(exp_txn.size() == 0, "R2 all matches strobed", exp_txn.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule